// File: doc/BRIEF.md
# Guard-Bit Mantissa Rounding Unit

This combinational unit finishes the rounding step of a floating-point result before it is packed into a storage format. Its input is a mantissa that still carries two extra low-order bits, a guard bit and a round bit, together with a separate sticky bit. The sticky bit records whether any nonzero bits were shifted out below them. The unit always removes the two extra bits. Depending on the rounding-mode code, the sign and the discarded bits, it may then add one to the remaining mantissa. It reports whether it rounded up and whether the result is inexact.

The same mode decode also drives a flag for the format packer. When the exponent overflows, this flag tells the packer whether the result becomes infinity or the largest finite magnitude of that sign. The unit does not renormalise. When the increment carries out of the top bit, it raises a carry flag, and the caller adjusts the exponent. Exponent arithmetic and format packing stay with the caller.

Top module: `guard_round_unit`

## Requirements
- R1: The output mantissa `mant_o` is input bits `[MANT_W-1:2]`, shifted down by two places, plus one if and only if an increment is chosen. Input bit 1 is the guard bit and bit 0 is the round bit. Neither bit appears in the output.
- R2: When the guard, round and sticky bits are all zero, no increment happens and `inexact_o` is 0, whatever the mode or sign.
- R3: When any of the guard, round or sticky bits is set, `inexact_o` is 1 in every mode, including toward zero.
- R4: In mode 0 (nearest) and in any code treated as nearest, an increment happens only when the guard bit is 1 and at least one of the following is 1: the round bit, the sticky bit, or bit 0 of the shifted mantissa. A tie therefore rounds to even.
- R5: In mode 1 (toward zero), no increment ever happens.
- R6: In mode 2 (toward plus infinity), an inexact value increments only when `sign_i` is 0. In mode 3 (toward minus infinity), an inexact value increments only when `sign_i` is 1.
- R7: The increment carries through the full output width. A shifted mantissa of all ones that is incremented gives `mant_o` equal to zero and `carry_o` equal to 1. In every other case `carry_o` is 0.
- R8: `rounded_up_o` is 1 exactly when the increment was applied.
- R9: `ovf_inf_o` is 1 in mode 0 and 0 in mode 1. In mode 2 it equals the inverse of `sign_i`, and in mode 3 it equals `sign_i`. It does not depend on the mantissa or the sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mant_i | input | MANT_W | Mantissa; bit 1 = guard, bit 0 = round |
| sticky_i | input | 1 | OR of all bits already shifted out below the round bit |
| mode_i | input | 2 | Rounding mode: 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_o | output | MANT_W-2 | Rounded mantissa with guard and round bits removed |
| carry_o | output | 1 | Increment carried out of the top output bit |
| rounded_up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Discarded bits were nonzero |
| ovf_inf_o | output | 1 | On overflow the packer should produce infinity (else largest finite) |

## Verification
Random mantissas almost never reach the full-width carry. To get one, the shifted mantissa must be all ones and an increment must also be chosen. The bench therefore drives an all-ones upper field in every mode and with both signs, paired with each guard, round and sticky combination. The exact ties in nearest mode are also uncommon under random stimulus. These cases are guard set, round and sticky clear, with both even and odd low bits. They are walked explicitly before the random phase starts.

// File: rtl/grnd_pkg.sv
package grnd_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_PINF = 2'd2,
    RM_MINF = 2'd3
  } rmode_e;

  // Nearest-even decision: the halfway point or beyond, with ties broken by the kept LSB
  function automatic logic near_even_up(input logic g, input logic r,
                                        input logic s, input logic lsb);
    return g & (r | s | lsb);
  endfunction

  // Any nonzero discarded information makes the result inexact
  function automatic logic lost_bits(input logic g, input logic r, input logic s);
    return g | r | s;
  endfunction

endpackage

// File: rtl/grnd_decide.sv
module grnd_decide
  import grnd_pkg::*;
(
  input  logic       sign_i,
  input  logic       guard_i,
  input  logic       round_i,
  input  logic       sticky_i,
  input  logic       lsb_i,
  input  logic [1:0] mode_i,
  output logic       inexact_o,
  output logic       bump_o,
  output logic       ovf_inf_o
);

  logic lost;
  assign lost = lost_bits(guard_i, round_i, sticky_i);

  always_comb begin
    inexact_o = lost;
    case (rmode_e'(mode_i))
      RM_ZERO: begin
        bump_o    = 1'b0;
        ovf_inf_o = 1'b0;
      end
      RM_PINF: begin
        bump_o    = lost & ~sign_i;
        ovf_inf_o = ~sign_i;
      end
      RM_MINF: begin
        bump_o    = lost & sign_i;
        ovf_inf_o = sign_i;
      end
      default: begin
        bump_o    = near_even_up(guard_i, round_i, sticky_i, lsb_i);
        ovf_inf_o = 1'b1;
      end
    endcase
  end

  // R5: toward-zero never asks for an increment
  always_comb begin
    if (mode_i == 2'd1)
      a_r5_rtz_no_bump: assert (!bump_o);
  end

endmodule

// File: rtl/grnd_incr.sv
module grnd_incr #(
  parameter int W = 26
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W:0] chain;
  assign chain[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]     = a_i[i] ^ chain[i];
    assign chain[i + 1] = a_i[i] & chain[i];
  end

  assign cout_o = chain[W];

  // R7: a carry out can only come from an all-ones operand with carry in
  always_comb begin
    if (cout_o)
      a_r7_carry_source: assert (cin_i && (&a_i) && (sum_o == '0));
  end

endmodule

// File: rtl/guard_round_unit.sv
module guard_round_unit #(
  parameter int MANT_W = 28
) (
  input  logic              sign_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [1:0]        mode_i,
  output logic [MANT_W-3:0] mant_o,
  output logic              carry_o,
  output logic              rounded_up_o,
  output logic              inexact_o,
  output logic              ovf_inf_o
);

  localparam int NG    = 2;
  localparam int OUT_W = MANT_W - NG;

  // Internal events brought out by name for the checks below
  logic [OUT_W-1:0] kept_w;
  logic             guard_w;
  logic             round_w;
  logic             bump_w;

  assign kept_w  = mant_i[MANT_W-1:NG];
  assign guard_w = mant_i[1];
  assign round_w = mant_i[0];

  grnd_decide u_decide (
    .sign_i    (sign_i),
    .guard_i   (guard_w),
    .round_i   (round_w),
    .sticky_i  (sticky_i),
    .lsb_i     (kept_w[0]),
    .mode_i    (mode_i),
    .inexact_o (inexact_o),
    .bump_o    (bump_w),
    .ovf_inf_o (ovf_inf_o)
  );

  grnd_incr #(.W(OUT_W)) u_incr (
    .a_i    (kept_w),
    .cin_i  (bump_w),
    .sum_o  (mant_o),
    .cout_o (carry_o)
  );

  assign rounded_up_o = bump_w;

  always_comb begin
    // R2: exact input never rounds and never flags inexact
    if (!guard_w && !round_w && !sticky_i)
      a_r2_exact_quiet: assert (!inexact_o && !rounded_up_o && mant_o == kept_w);
    // R3: lost bits always flag inexact
    if (guard_w || round_w || sticky_i)
      a_r3_inexact_set: assert (inexact_o);
    // R8: the up flag matches what the adder produced
    a_r8_up_matches_sum: assert (rounded_up_o == ({carry_o, mant_o} != {1'b0, kept_w}));
    // R4: nearest without guard bit never rounds
    if (mode_i == 2'd0 && !guard_w)
      a_r4_near_below_half: assert (!rounded_up_o);
    // R9: overflow direction per mode
    if (mode_i == 2'd1)
      a_r9_rtz_finite: assert (!ovf_inf_o);
    if (mode_i == 2'd0)
      a_r9_near_inf: assert (ovf_inf_o);
  end

endmodule

// File: tb/guard_round_unit_tb.sv
module guard_round_unit_tb;

  localparam int MANT_W = 28;
  localparam int OUT_W  = MANT_W - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              sign_i;
  logic [MANT_W-1:0] mant_i;
  logic              sticky_i;
  logic [1:0]        mode_i;
  logic [OUT_W-1:0]  mant_o;
  logic              carry_o, rounded_up_o, inexact_o, ovf_inf_o;

  guard_round_unit #(.MANT_W(MANT_W)) u_dut (
    .sign_i(sign_i), .mant_i(mant_i), .sticky_i(sticky_i), .mode_i(mode_i),
    .mant_o(mant_o), .carry_o(carry_o), .rounded_up_o(rounded_up_o),
    .inexact_o(inexact_o), .ovf_inf_o(ovf_inf_o)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural reference: plain integer arithmetic on the written rules
  task automatic expect_out(input string tag);
    logic [OUT_W:0] base, res;
    bit g, r, lost, up, inf;
    base = {1'b0, mant_i[MANT_W-1:2]};
    g = mant_i[1];
    r = mant_i[0];
    lost = (g || r || sticky_i);
    if (mode_i == 2'd1) begin
      up = 0; inf = 0;
    end else if (mode_i == 2'd2) begin
      up = lost && !sign_i; inf = !sign_i;
    end else if (mode_i == 2'd3) begin
      up = lost && sign_i; inf = sign_i;
    end else begin
      up = g && (r || sticky_i || (base % 2 == 1)); inf = 1;
    end
    res = base + (up ? 1 : 0);
    checks++;
    if ({carry_o, mant_o} !== res || rounded_up_o !== up ||
        inexact_o !== lost || ovf_inf_o !== inf) begin
      errors++;
      $display("FAIL %s: mode=%0d sign=%0b mant=%h st=%0b got {c,m}=%h up=%0b nx=%0b inf=%0b exp {c,m}=%h up=%0b nx=%0b inf=%0b",
               tag, mode_i, sign_i, mant_i, sticky_i, {carry_o, mant_o}, rounded_up_o,
               inexact_o, ovf_inf_o, res, up, lost, inf);
    end
  endtask

  task automatic apply(input bit s, input logic [MANT_W-1:0] m, input bit st,
                       input logic [1:0] md, input string tag);
    @(posedge clk);
    #1;
    sign_i = s; mant_i = m; sticky_i = st; mode_i = md;
    @(negedge clk);
    expect_out(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    sign_i = 0; mant_i = '0; sticky_i = 0; mode_i = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_out("R2 idle-zero");
    rst_n = 1'b1;

    // R1/R2: exact values pass through shifted, every mode and sign
    for (int md = 0; md < 4; md++)
      for (int s = 0; s < 2; s++)
        apply(s[0], 28'h5A3C_F00, 1'b0, md[1:0], "R1 R2 exact shift");

    // R3: inexact in every mode, each lost-bit source
    for (int md = 0; md < 4; md++)
      for (int gr = 0; gr < 4; gr++)
        for (int st = 0; st < 2; st++)
          if (gr != 0 || st != 0)
            apply(md[0], {24'h123456, 2'b01, gr[1:0]}, st[0], md[1:0], "R3 inexact");

    // R4: nearest ties to even, above and below half
    apply(0, {26'h0000010, 2'b10}, 0, 2'd0, "R4 tie even stays");
    apply(0, {26'h0000011, 2'b10}, 0, 2'd0, "R4 tie odd rounds");
    apply(1, {26'h0000010, 2'b11}, 0, 2'd0, "R4 above half");
    apply(1, {26'h0000010, 2'b10}, 1, 2'd0, "R4 tie broken by sticky");
    apply(0, {26'h0000011, 2'b01}, 1, 2'd0, "R4 below half");

    // R5: toward zero never increments
    apply(0, {26'h3FFFFFF, 2'b11}, 1, 2'd1, "R5 rtz max");
    apply(1, {26'h0000001, 2'b10}, 0, 2'd1, "R5 rtz neg");

    // R6: directed modes by sign
    apply(0, {26'h0000100, 2'b01}, 0, 2'd2, "R6 +inf pos up");
    apply(1, {26'h0000100, 2'b01}, 0, 2'd2, "R6 +inf neg down");
    apply(1, {26'h0000100, 2'b00}, 1, 2'd3, "R6 -inf neg up");
    apply(0, {26'h0000100, 2'b00}, 1, 2'd3, "R6 -inf pos down");

    // R7/R8: full-width carry, every mode and sign with all-ones kept field
    for (int md = 0; md < 4; md++)
      for (int s = 0; s < 2; s++)
        for (int gr = 0; gr < 4; gr++)
          for (int st = 0; st < 2; st++)
            apply(s[0], {26'h3FFFFFF, gr[1:0]}, st[0], md[1:0], "R7 R8 carry out");

    // R9: overflow direction with zero mantissa (independent of mantissa)
    for (int md = 0; md < 4; md++)
      for (int s = 0; s < 2; s++)
        apply(s[0], '0, 1'b0, md[1:0], "R9 overflow direction");

    // Random sweep compared every clock
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(0, 1) == 1, MANT_W'($urandom), $urandom_range(0, 1) == 1,
            2'($urandom_range(0, 3)), "R4 R6 R8 random");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule